// File: doc/BRIEF.md
# Set-Associative Cache Controller

This controller sits between a processor load/store port and a memory port that moves one 32-bit word at a time. It is configured by parameters for the number of ways, the number of sets and the number of words per line. A lookup compares the tag against every way of the indexed set. Hits are served without any memory traffic. A miss asks an external replacement unit which way to use. If that way holds a dirty line under write-back, the line is written out. The new line is then refilled word by word.

A two-bit mode input selects the write policy: write-back, write-through with allocation, or write-through without allocation. Addresses in the top sixteenth of the address space always go straight to memory, and so does every access while the enable input is low. A flush command writes back every dirty line and invalidates the whole array. An invalidate command drops every line without writing anything.

The processor holds its request, with address and data stable, until it sees ready. Ready is high in the cycle in which the access completes, and read data is valid in that cycle. Commands use the same rule with their own done output.

Top module: `cache_ctrl`

## Requirements
- R1: After reset every line is invalid, no memory request is issued, and the first cached access to any address is a miss.
- R2: An access with address from 0xF0000000 to 0xFFFFFFFF inclusive, or any access while enable is low, makes exactly one memory access at the request address with the request's direction. It allocates nothing, and its ready comes with that access's acknowledge.
- R3: The lookup takes the first way, in ascending order, that is valid with a matching tag. A read hit, and a write hit under write-back, raises ready in the same cycle as the request and makes no memory access. At most one way ever matches.
- R4: The address is split as follows: bits [1:0] are ignored, the next log2(words) bits select the word, the next log2(sets) bits select the set, and the remaining upper bits are the tag. A line's base byte address is ((tag*words*sets)+set*words)*4.
- R5: A refill reads every word of the line, one at a time, at ascending word addresses from the line base. The requested word is then served from the line.
- R6: Replacing a valid line writes all its words to memory, in ascending order, before the refill. This happens only if the line is dirty and the mode is write-back; otherwise the line is dropped silently.
- R7: Mode encoding: 0 is write-back, 1 is write-through with allocation, 2 (and 3) is write-through without allocation. In both write-through modes every cached write also issues one memory write of the request data. Under write-back a cached write only updates the line and marks it dirty.
- R8: Under write-through without allocation, a write miss issues one memory write and allocates no line, so a later read of that address misses.
- R9: Flush visits lines in order way 0 sets ascending, then way 1 and so on. It writes back every valid dirty line under write-back and leaves all lines invalid. Its done output is never high together with ready.
- R10: Invalidate completes in the cycle it is requested and issues no memory access. A dirty line's data is lost, so a later read returns the memory value.
- R11: On a miss that allocates, the controller raises repl_req with the set index. It holds both until repl_ack, and then uses repl_way as the victim.
- R12: The memory port has at most one request outstanding. A request keeps its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Cache enable; low makes every access bypass |
| wmode | input | 2 | Write policy select |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with ready |
| flush_req | input | 1 | Flush command, held until done |
| inval_req | input | 1 | Invalidate-all command, held until done |
| cmd_done | output | 1 | Command completes this cycle |
| repl_req | output | 1 | Victim request to the replacement unit |
| repl_set | output | log2(SETS) | Set the victim is wanted for |
| repl_ack | input | 1 | Victim response valid |
| repl_way | input | log2(WAYS) | Chosen victim way |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request accepted/completed |
| mem_rdata | input | 32 | Memory read data, valid with ack |

## Verification
Every cycle, the assertions check four things: at most one way matches, a memory or victim request holds until it is answered, a bypass or write-through completion coincides with the memory acknowledge, and command completion never overlaps an access completion. The behaviours that need history can only be shown by the bench's scenarios, which predict the exact stream of memory words. They cover the refill order and line base address, write-back of dirty victims in write-back mode only, write-through forwarding, the absence of allocation on a no-allocate write miss, flush order, and loss of dirty data on invalidate.

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [1:0]                wmode,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [31:0]               cpu_addr,
  input  logic [31:0]               cpu_wdata,
  output logic                      cpu_ready,
  output logic [31:0]               cpu_rdata,
  input  logic                      flush_req,
  input  logic                      inval_req,
  output logic                      cmd_done,
  output logic                      repl_req,
  output logic [$clog2(SETS)-1:0]   repl_set,
  input  logic                      repl_ack,
  input  logic [$clog2(WAYS)-1:0]   repl_way,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [31:0]               mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_ack,
  input  logic [31:0]               mem_rdata
);
  localparam int WAYB  = $clog2(WAYS);
  localparam int SETB  = $clog2(SETS);
  localparam int COLB  = $clog2(WORDS);
  localparam int TAGW  = 32 - 2 - COLB - SETB;
  localparam int LINES = WAYS * SETS;
  localparam int LB    = WAYB + SETB;

  typedef enum logic [2:0] {S_IDLE, S_REPL, S_EVICT, S_FILL, S_WTHRU, S_BYP, S_FLUSH} st_t;

  logic [31:0]     dat [LINES*WORDS];
  logic [TAGW-1:0] tg  [LINES];
  logic [LINES-1:0] vl, dt;

  st_t              st;
  logic [COLB-1:0]  wc;
  logic [WAYB-1:0]  sway;
  logic [SETB-1:0]  sset;
  logic [LB-1:0]    fidx;
  logic             infl;

  wire [COLB-1:0] col = cpu_addr[2 +: COLB];
  wire [SETB-1:0] row = cpu_addr[2+COLB +: SETB];
  wire [TAGW-1:0] tag = cpu_addr[31 -: TAGW];
  wire uncached = !enable || (cpu_addr[31:28] == 4'hF);
  wire wb_mode  = (wmode == 2'd0);
  wire noalloc  = wmode[1];

  logic [WAYS-1:0] match;
  logic [WAYB-1:0] hway;
  always_comb begin
    hway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      match[w] = vl[{w[WAYB-1:0], row}] && (tg[{w[WAYB-1:0], row}] == tag);
      if (match[w]) hway = w[WAYB-1:0];
    end
  end

  wire          hit   = |match;
  wire [LB-1:0] hline = {hway, row};
  wire [LB-1:0] sline = {sway, sset};
  wire [LB-1:0] rline = {repl_way, row};
  wire          last  = (wc == COLB'(WORDS - 1));
  wire          fneed = vl[fidx] && dt[fidx] && wb_mode;
  wire          flast = (fidx == LB'(LINES - 1));
  wire          idle  = (st == S_IDLE);
  wire          cpu_go = idle && !inval_req && !flush_req && cpu_req;

  assign cpu_ready = (cpu_go && !uncached && hit && (!cpu_we || wb_mode)) ||
                     ((st == S_WTHRU || st == S_BYP) && mem_ack);
  assign cmd_done  = (idle && inval_req) || (st == S_FLUSH && !fneed && flast);
  assign cpu_rdata = idle ? dat[{hline, col}] : mem_rdata;
  assign repl_req  = (st == S_REPL);
  assign repl_set  = row;
  assign mem_req   = (st == S_EVICT) || (st == S_FILL) || (st == S_WTHRU) || (st == S_BYP);
  assign mem_we    = (st == S_EVICT) || (st == S_WTHRU) || (st == S_BYP && cpu_we);
  assign mem_addr  = (st == S_EVICT) ? {tg[sline], sset, wc, 2'b00} :
                     (st == S_FILL)  ? {tag, row, wc, 2'b00} : cpu_addr;
  assign mem_wdata = (st == S_EVICT) ? dat[{sline, wc}] : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      vl   <= '0;
      dt   <= '0;
      wc   <= '0;
      sway <= '0;
      sset <= '0;
      fidx <= '0;
      infl <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (inval_req) begin
            vl <= '0;
            dt <= '0;
          end else if (flush_req) begin
            fidx <= '0;
            st   <= S_FLUSH;
          end else if (cpu_req) begin
            if (uncached) st <= S_BYP;
            else if (hit) begin
              if (cpu_we) begin
                dat[{hline, col}] <= cpu_wdata;
                dt[hline] <= 1'b1;
                if (!wb_mode) st <= S_WTHRU;
              end
            end else if (cpu_we && noalloc) st <= S_BYP;
            else st <= S_REPL;
          end
        end
        S_REPL: if (repl_ack) begin
          sway <= repl_way;
          sset <= row;
          wc   <= '0;
          infl <= 1'b0;
          if (vl[rline] && dt[rline] && wb_mode) st <= S_EVICT;
          else begin
            vl[rline] <= 1'b0;
            dt[rline] <= 1'b0;
            st <= S_FILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          wc <= wc + 1'b1;
          if (last) begin
            vl[sline] <= 1'b0;
            dt[sline] <= 1'b0;
            st <= infl ? S_FLUSH : S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          dat[{sline, wc}] <= mem_rdata;
          wc <= wc + 1'b1;
          if (last) begin
            vl[sline] <= 1'b1;
            dt[sline] <= 1'b0;
            tg[sline] <= tag;
            st <= S_IDLE;
          end
        end
        S_WTHRU, S_BYP: if (mem_ack) st <= S_IDLE;
        S_FLUSH: begin
          if (fneed) begin
            sway <= fidx[LB-1:SETB];
            sset <= fidx[SETB-1:0];
            wc   <= '0;
            infl <= 1'b1;
            st   <= S_EVICT;
          end else begin
            vl[fidx] <= 1'b0;
            dt[fidx] <= 1'b0;
            if (flast) begin
              st   <= S_IDLE;
              infl <= 1'b0;
            end else fidx <= fidx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));

  // R11
  repl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl_req && !repl_ack |=> repl_req && $stable(repl_set));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R2
  mem_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && mem_req |-> mem_ack);

  // R9
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !cpu_ready);
endmodule

// File: tb/test_cache_ctrl.sv
`timescale 1ns/1ps
module test_cache_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
  logic [1:0] wmode = 2'd0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic flush_req = 0, inval_req = 0, cmd_done;
  logic repl_req, repl_ack = 0;
  logic [1:0] repl_set;
  logic repl_way = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  always #2 clk = ~clk;

  cache_ctrl i_cache_ctrl (.clk(clk), .rst_n(rst_n), .enable(enable), .wmode(wmode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .flush_req(flush_req), .inval_req(inval_req),
    .cmd_done(cmd_done), .repl_req(repl_req), .repl_set(repl_set), .repl_ack(repl_ack),
    .repl_way(repl_way), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int total = 0, bad = 0;
  int lat = 0, lcnt = 0, rcnt = 0;
  bit victim = 0;
  logic [1:0] exp_row = 0;

  bit mv [2][4];
  bit md [2][4];
  logic [25:0] mt [2][4];
  logic [31:0] mdat [2][4][4];
  logic [31:0] refmem [int unsigned];
  logic [31:0] bmem [int unsigned];
  logic [64:0] expq [$];

  task automatic chk(string r, string what, logic [64:0] act, logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] defv(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_3C3C;
  endfunction
  function automatic logic [31:0] rget(logic [31:0] a);
    if (refmem.exists(a >> 2)) return refmem[a >> 2];
    return defv(a);
  endfunction

  function automatic void push(bit we, logic [31:0] a, logic [31:0] d);
    expq.push_back({we, a, we ? d : 32'h0});
    if (we) refmem[a >> 2] = d;
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (lcnt >= lat) begin
        logic [64:0] e;
        mem_ack = 1'b1;
        lcnt = 0;
        if (expq.size() == 0) chk("R12", "unexpected mem op", {mem_we, mem_addr, mem_wdata}, 65'h0);
        else begin
          e = expq.pop_front();
          chk("R4", "mem op", {mem_we, mem_addr, mem_we ? mem_wdata : 32'h0}, e);
        end
        if (mem_we) bmem[mem_addr >> 2] = mem_wdata;
        else mem_rdata = bmem.exists(mem_addr >> 2) ? bmem[mem_addr >> 2] : defv(mem_addr);
      end else begin
        mem_ack = 1'b0;
        lcnt++;
      end
    end else begin
      mem_ack = 1'b0;
      lcnt = 0;
    end
    if (repl_req) begin
      if (rcnt >= 1) begin
        repl_ack = 1'b1;
        repl_way = victim;
        rcnt = 0;
        chk("R11", "victim set", {63'h0, repl_set}, {63'h0, exp_row});
      end else begin
        repl_ack = 1'b0;
        rcnt++;
      end
    end else begin
      repl_ack = 1'b0;
      rcnt = 0;
    end
  end

  task automatic model(bit we, logic [31:0] a, logic [31:0] d, output logic [31:0] er, output bit fast);
    logic [1:0] c, r;
    logic [25:0] t;
    int hw;
    c = a[3:2]; r = a[5:4]; t = a[31:6];
    fast = 0;
    if (!enable || a[31:28] == 4'hF) begin
      push(we, a, d);
      er = rget(a);
      return;
    end
    hw = -1;
    for (int w = 1; w >= 0; w--) if (mv[w][r] && mt[w][r] == t) hw = w;
    if (hw >= 0) fast = !we || wmode == 2'd0;
    else if (we && wmode[1]) begin
      push(1, a, d);
      er = 0;
      return;
    end else begin
      exp_row = r;
      hw = int'(victim);
      if (mv[hw][r] && md[hw][r] && wmode == 2'd0)
        for (int k = 0; k < 4; k++) push(1, {mt[hw][r], r, k[1:0], 2'b00}, mdat[hw][r][k]);
      for (int k = 0; k < 4; k++) begin
        push(0, {t, r, k[1:0], 2'b00}, 0);
        mdat[hw][r][k] = rget({t, r, k[1:0], 2'b00});
      end
      mv[hw][r] = 1; md[hw][r] = 0; mt[hw][r] = t;
    end
    if (we) begin
      mdat[hw][r][c] = d;
      md[hw][r] = 1;
      if (wmode != 2'd0) push(1, a, d);
    end
    er = mdat[hw][r][c];
  endtask

  task automatic access(string r, bit we, logic [31:0] a, logic [31:0] d, bit v);
    logic [31:0] er;
    bit fast;
    int waits;
    victim = v;
    model(we, a, d, er, fast);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    forever begin
      @(negedge clk); #1;
      if (cpu_ready) break;
      waits++;
      if (waits > 5000) begin
        chk(r, "ready timeout", 0, 1);
        break;
      end
    end
    if (!we) chk(r, "read data", {33'h0, cpu_rdata}, {33'h0, er});
    if (fast) chk("R3", "zero-wait hit", waits, 0);
    else chk(r, "access waited", {64'h0, waits > 0}, 65'h1);
    @(posedge clk); #1;
    cpu_req = 0;
    chk(r, "leftover mem ops", expq.size(), 0);
  endtask

  task automatic command(string r, bit fl);
    int waits;
    if (fl) begin
      for (int i = 0; i < 8; i++) begin
        if (mv[i/4][i%4] && md[i/4][i%4] && wmode == 2'd0)
          for (int k = 0; k < 4; k++)
            push(1, {mt[i/4][i%4], 2'(i%4), k[1:0], 2'b00}, mdat[i/4][i%4][k]);
        mv[i/4][i%4] = 0; md[i/4][i%4] = 0;
      end
      flush_req = 1;
    end else begin
      for (int i = 0; i < 8; i++) begin mv[i/4][i%4] = 0; md[i/4][i%4] = 0; end
      inval_req = 1;
    end
    waits = 0;
    forever begin
      @(negedge clk); #1;
      if (cmd_done) break;
      waits++;
      if (waits > 5000) begin chk(r, "done timeout", 0, 1); break; end
    end
    if (!fl) chk("R10", "invalidate same cycle", waits, 0);
    @(posedge clk); #1;
    flush_req = 0; inval_req = 0;
    chk(r, "leftover mem ops", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("R12", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mv[i/4][i%4] = 0; md[i/4][i%4] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset outputs", {62'h0, cpu_ready, mem_req, cmd_done}, 65'h0);
    rst_n = 1;
    @(posedge clk); #1;
    // R1 R4 R5 first access misses and refills
    access("R5", 0, 32'h0000_0104, 0, 0);
    access("R3", 0, 32'h0000_0100, 0, 0);
    access("R7", 1, 32'h0000_0108, 32'h1111_1111, 0);
    access("R3", 0, 32'h0000_0108, 0, 0);
    lat = 2;
    access("R5", 0, 32'h0000_020C, 0, 1);
    access("R6", 0, 32'h0000_0300, 0, 0);
    access("R6", 0, 32'h0000_0108, 0, 1);
    lat = 1;
    access("R4", 1, 32'h0000_0424, 32'h2222_2222, 0);
    command("R9", 1);
    access("R9", 0, 32'h0000_0424, 0, 1);
    // R7 write-through with allocation
    wmode = 2'd1;
    access("R7", 1, 32'h0000_0530, 32'h3333_3333, 0);
    access("R7", 1, 32'h0000_0534, 32'h4444_4444, 0);
    access("R3", 0, 32'h0000_0534, 0, 0);
    access("R6", 0, 32'h0000_0630, 0, 0);
    // R8 write-through without allocation
    wmode = 2'd2;
    access("R8", 1, 32'h0000_0714, 32'h5555_5555, 0);
    access("R8", 0, 32'h0000_0714, 0, 0);
    // R2 uncached window and disable
    lat = 0;
    access("R2", 0, 32'hF000_0010, 0, 0);
    access("R2", 1, 32'hFFFF_FFFC, 32'h6666_6666, 0);
    access("R2", 0, 32'hFFFF_FFFC, 0, 0);
    access("R2", 0, 32'hEFFF_FFFC, 0, 1);
    enable = 0;
    access("R2", 0, 32'h0000_0534, 0, 0);
    enable = 1;
    // R10 invalidate drops dirty data
    wmode = 2'd0;
    access("R10", 1, 32'h0000_0840, 32'h7777_7777, 0);
    refmem[32'h0000_0840 >> 2] = bmem.exists(32'h840 >> 2) ? bmem[32'h840 >> 2] : defv(32'h840);
    command("R10", 0);
    access("R10", 0, 32'h0000_0840, 0, 1);
    chk("R10", "dirty data lost", {33'h0, cpu_rdata}, {33'h0, defv(32'h840)});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule